// File: doc/BRIEF.md
# Millisecond Timer Interrupt Controller

This block supplies a processor with a programmable periodic timer interrupt and merges it with two external event sources: a byte arriving at a serial receiver and a key press from a keyboard receiver. Software programs the timer by writing a period, counted in milliseconds, to a fixed output port number. A prescaler derives a one-millisecond tick from the system clock. An internal counter advances on each tick and raises the timer request when it reaches the programmed period.

Every source pulse sets a sticky pending bit. The processor signals the end of each instruction with a one-cycle boundary strobe. On such a strobe, if anything is pending, the block picks the highest-priority source and clears only that bit. In the following cycle it presents a service strobe together with the handler vector and the source number. Requests are never serviced between boundaries.

Top module: `ms_irq_ctrl`

## Requirements
- R1: After reset the period is zero, no request is pending, `irq_take` is 0, `irq_id` is 3 and `irq_vec` is 0.
- R2: While the period is zero the timer counter stays at zero and no timer request is raised, however long the block runs.
- R3: Only a write (`io_wr`=1) with `io_port` equal to 129 loads the period from `io_wdata`. Writes to any other port number change nothing.
- R4: Writing a nonzero period P on clock edge W sets the timer pending bit on edge W + P*DIV + 1, where DIV = CLK_HZ/TICK_HZ. A boundary sampled on edge W + P*DIV + 1 therefore sees nothing, and one sampled on edge W + P*DIV + 2 services the timer.
- R5: After it fires, the timer counter returns to zero, and the timer request repeats every P*DIV clock cycles.
- R6: A period write clears both the timer counter and the prescaler phase, so the next request is timed from the write alone.
- R7: A one-cycle pulse on `uart_evt` or `kbd_evt` sets a pending bit that stays set until a boundary services it.
- R8: `irq_take` rises only in the cycle after a cycle with `insn_end`=1 and at least one pending bit. It lasts one cycle per boundary.
- R9: Fixed priority: the timer first, then the serial byte event, then the key event. Each boundary services exactly one source, and the others stay pending.
- R10: A service clears only the serviced bit. A new pulse on the same source in the boundary cycle keeps that bit set.
- R11: Vectors and ids: timer gives vector 8 and id 0, serial byte gives vector 12 and id 1, key gives vector 16 and id 2. With no service, the id is 3 and the vector is 0.
- R12: Writing period 0 stops the timer. No further timer requests follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Output-port write strobe |
| io_port | input | PORT_W | Output-port number |
| io_wdata | input | PERIOD_W | Output-port write data |
| uart_evt | input | 1 | One-cycle pulse: serial byte received |
| kbd_evt | input | 1 | One-cycle pulse: key pressed |
| insn_end | input | 1 | One-cycle strobe at the end of each instruction |
| irq_take | output | 1 | A request was serviced at the last boundary |
| irq_vec | output | VEC_W | Handler address for the serviced request |
| irq_id | output | 2 | Serviced source number, 3 when none |

## Verification
A wrong counter or prescaler phase shows up as a timer service one or more cycles early or late relative to the write edge. The bench probes the exact boundary edges around each expected firing, so such an error is exposed within a single period. A lost or stuck pending bit shows up at the next boundary as a missing, repeated or out-of-order vector. A spurious `irq_take` between boundaries is caught in the very cycle it appears, because the monitor watches every cycle.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_TIMER = 2'd0,
        SRC_UART  = 2'd1,
        SRC_KBD   = 2'd2,
        SRC_NONE  = 2'd3
    } irq_src_e;

endpackage

// File: rtl/irq_tick_gen.sv
`timescale 1ns/1ps
module irq_tick_gen #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    generate
        if (DIV < 2) begin : g_bad_div
            $error("irq_tick_gen: CLK_HZ/TICK_HZ must be at least 2");
        end
    endgenerate

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST);
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);                                            // R4
    AST_RESTART_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);                                         // R6

endmodule

// File: rtl/irq_period_timer.sv
`timescale 1ns/1ps
module irq_period_timer #(
    parameter int PERIOD_W   = 16,
    parameter int PORT_W     = 8,
    parameter int TIMER_PORT = 129
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic [PORT_W-1:0]   io_port,
    input  logic [PERIOD_W-1:0] io_wdata,
    input  logic                tick,
    output logic                reload,
    output logic                fire
);
    localparam logic [PORT_W-1:0] PORT_SEL = PORT_W'(TIMER_PORT);

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    assign reload = io_wr && (io_port == PORT_SEL);
    assign fire   = (st_q.period != '0) && (st_q.cnt == st_q.period);

    always_comb begin
        st_d = st_q;
        if (reload) begin
            st_d.period = io_wdata;
            st_d.cnt    = '0;
        end else if (st_q.period != '0) begin
            if (fire) begin
                st_d.cnt = '0;
            end else if (tick) begin
                st_d.cnt = st_q.cnt + PERIOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.period == '0) |-> (st_q.cnt == '0 && !fire));        // R2
    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(st_q.period));                          // R3
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.period);                                   // R4
    AST_FIRE_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.cnt == '0));                                 // R5
    AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (st_q.cnt == '0 && !fire));                      // R6

endmodule

// File: rtl/irq_pend_arb.sv
`timescale 1ns/1ps
module irq_pend_arb
    import irq_pkg::*;
#(
    parameter int VEC_W     = 32,
    parameter int VEC_TIMER = 8,
    parameter int VEC_UART  = 12,
    parameter int VEC_KBD   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_evt,
    input  logic             insn_end,
    output logic             take,
    output logic [VEC_W-1:0] vec,
    output logic [1:0]       id
);
    typedef struct packed {
        logic [NSRC-1:0]  pend;
        logic             take;
        irq_src_e         id;
        logic [VEC_W-1:0] vec;
    } arb_st_t;

    arb_st_t         st_d, st_q;
    irq_src_e        sel;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] pend_nxt;

    // highest priority pending source (lowest index wins)
    always_comb begin
        sel = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (st_q.pend[i]) begin
                sel = irq_src_e'(2'(i));
            end
        end
        clr = '0;
        if (insn_end && sel != SRC_NONE) begin
            clr = NSRC'(1) << sel;
        end
    end

    // per-source sticky bit: a new pulse outranks a clear
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            assign pend_nxt[i] = (st_q.pend[i] & ~clr[i]) | src_evt[i];

            AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.pend[i] && !insn_end) |=> st_q.pend[i]);      // R7
            AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                src_evt[i] |=> st_q.pend[i]);                       // R10
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
        st_d.take = insn_end && (sel != SRC_NONE);
        st_d.id   = SRC_NONE;
        st_d.vec  = '0;
        if (insn_end) begin
            st_d.id = sel;
            case (sel)
                SRC_TIMER: st_d.vec = VEC_W'(VEC_TIMER);
                SRC_UART:  st_d.vec = VEC_W'(VEC_UART);
                SRC_KBD:   st_d.vec = VEC_W'(VEC_KBD);
                default:   st_d.vec = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.id   <= SRC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign take = st_q.take;
    assign vec  = st_q.vec;
    assign id   = st_q.id;

    AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.take |-> $past(insn_end));                             // R8
    AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && st_q.pend[0]) |=> (st_q.take && st_q.id == SRC_TIMER)); // R9
    AST_UART_OVER_KBD: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && !st_q.pend[0] && st_q.pend[1]) |=> (st_q.id == SRC_UART)); // R9
    AST_SERVED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end && st_q.pend[0] && !src_evt[0]) |=> !st_q.pend[0]); // R10
    AST_ONE_PER_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        insn_end |=> ($countones($past(st_q.pend) & ~st_q.pend) <= 1)); // R9

endmodule

// File: rtl/ms_irq_ctrl.sv
`timescale 1ns/1ps
module ms_irq_ctrl
    import irq_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int TICK_HZ    = 1000,
    parameter int PORT_W     = 8,
    parameter int PERIOD_W   = 16,
    parameter int TIMER_PORT = 129,
    parameter int VEC_W      = 32,
    parameter int VEC_TIMER  = 8,
    parameter int VEC_UART   = 12,
    parameter int VEC_KBD    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                io_wr,
    input  logic [PORT_W-1:0]   io_port,
    input  logic [PERIOD_W-1:0] io_wdata,
    input  logic                uart_evt,
    input  logic                kbd_evt,
    input  logic                insn_end,
    output logic                irq_take,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [1:0]          irq_id
);
    logic            ms_tick;
    logic            reload;
    logic            timer_fire;
    logic [NSRC-1:0] src_evt;

    irq_tick_gen #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reload),
        .tick    (ms_tick)
    );

    irq_period_timer #(
        .PERIOD_W   (PERIOD_W),
        .PORT_W     (PORT_W),
        .TIMER_PORT (TIMER_PORT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_port  (io_port),
        .io_wdata (io_wdata),
        .tick     (ms_tick),
        .reload   (reload),
        .fire     (timer_fire)
    );

    assign src_evt = {kbd_evt, uart_evt, timer_fire};

    irq_pend_arb #(
        .VEC_W     (VEC_W),
        .VEC_TIMER (VEC_TIMER),
        .VEC_UART  (VEC_UART),
        .VEC_KBD   (VEC_KBD)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .insn_end (insn_end),
        .take     (irq_take),
        .vec      (irq_vec),
        .id       (irq_id)
    );

endmodule

// File: tb/sim_ms_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ms_irq_ctrl;
    localparam int CLK_HZ  = 10_000;
    localparam int TICK_HZ = 1000;
    localparam int DIV     = CLK_HZ / TICK_HZ;
    localparam int PW      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [PW-1:0] io_wdata = '0;
    logic        uart_evt = 1'b0;
    logic        kbd_evt = 1'b0;
    logic        insn_end = 1'b0;
    logic        irq_take;
    logic [31:0] irq_vec;
    logic [1:0]  irq_id;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit bnd_q = 1'b0;
    bit done = 1'b0;

    bit          exp_v_q[$];
    logic [31:0] exp_vec_q[$];
    logic [1:0]  exp_id_q[$];
    string       exp_tag_q[$];

    ms_irq_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .TICK_HZ  (TICK_HZ),
        .PERIOD_W (PW)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_port  (io_port),
        .io_wdata (io_wdata),
        .uart_evt (uart_evt),
        .kbd_evt  (kbd_evt),
        .insn_end (insn_end),
        .irq_take (irq_take),
        .irq_vec  (irq_vec),
        .irq_id   (irq_id)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        bnd_q <= insn_end;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per boundary, otherwise demands silence
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bnd_q) begin
                if (exp_v_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R8 scoreboard empty actual=%0d expected=none", irq_take);
                end else begin
                    automatic bit          v   = exp_v_q.pop_front();
                    automatic logic [31:0] ev  = exp_vec_q.pop_front();
                    automatic logic [1:0]  eid = exp_id_q.pop_front();
                    automatic string       t   = exp_tag_q.pop_front();
                    check({t, " take"}, 32'(irq_take), 32'(v));
                    if (v) begin
                        check({t, " vec"}, irq_vec, ev);
                        check({t, " id"}, 32'(irq_id), 32'(eid));
                    end
                end
            end else if (irq_take !== 1'b0) begin
                total++; bad++;
                $display("FAIL R8 take without boundary actual=%0d expected=0", irq_take);
            end
        end
    end

    task automatic push(input bit v, input logic [31:0] vec, input logic [1:0] id, input string tag);
        exp_v_q.push_back(v);
        exp_vec_q.push_back(vec);
        exp_id_q.push_back(id);
        exp_tag_q.push_back(tag);
    endtask

    // boundary sampled on posedge number e
    task automatic boundary_at(input int e, input bit v, input logic [31:0] vec,
                               input logic [1:0] id, input string tag);
        while (cyc < e - 1) @(negedge clk);
        push(v, vec, id, tag);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
    endtask

    task automatic boundary(input bit v, input logic [31:0] vec,
                            input logic [1:0] id, input string tag);
        boundary_at(cyc + 1, v, vec, id, tag);
    endtask

    task automatic write_port(input logic [7:0] p, input logic [PW-1:0] d, output int wedge);
        io_wr = 1'b1; io_port = p; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        wedge = cyc;
    endtask

    task automatic pulse(input bit u, input bit k);
        uart_evt = u; kbd_evt = k;
        @(negedge clk);
        uart_evt = 1'b0; kbd_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        int w, w2, wz;
        repeat (4) @(negedge clk);
        check("R1 take in reset", 32'(irq_take), 0);
        check("R1 id in reset", 32'(irq_id), 3);
        check("R1 vec in reset", irq_vec, 0);
        rst_n = 1'b1;
        @(negedge clk);
        boundary(0, 0, 0, "R1 nothing pending");

        idle(100);
        boundary(0, 0, 0, "R2 zero period idle");

        write_port(8'd128, 16'd2, w);
        boundary_at(w + 40, 0, 0, 0, "R3 other port ignored");

        write_port(8'd129, 16'd3, w);
        boundary_at(w + 3*DIV + 1, 0, 0, 0, "R4 one edge early");
        boundary_at(w + 3*DIV + 2, 1, 8, 0, "R4 first timer");
        boundary_at(w + 6*DIV + 1, 0, 0, 0, "R5 early second");
        boundary_at(w + 6*DIV + 2, 1, 8, 0, "R5 second timer");

        idle(2);
        write_port(8'd129, 16'd2, w2);
        boundary_at(w2 + 2*DIV + 1, 0, 0, 0, "R6 restart early");
        boundary_at(w2 + 2*DIV + 2, 1, 8, 0, "R6 restart timing");

        write_port(8'd129, 16'd0, wz);
        idle(100);
        boundary(0, 0, 0, "R12 stopped");

        pulse(1, 0);
        idle(30);
        boundary(1, 12, 1, "R7 serial sticky");
        boundary(0, 0, 0, "R7 serial cleared");
        pulse(0, 1);
        idle(5);
        boundary(1, 16, 2, "R11 key vector");
        boundary(0, 0, 0, "R11 key cleared");

        write_port(8'd129, 16'd1, w);
        while (cyc < w + DIV + 2) @(negedge clk);
        pulse(1, 1);
        write_port(8'd129, 16'd0, wz);
        boundary(1, 8, 0, "R9 timer first");
        boundary(1, 12, 1, "R9 serial second");
        boundary(1, 16, 2, "R9 key third");
        boundary(0, 0, 0, "R9 all drained");

        pulse(1, 0);
        push(1, 12, 1, "R10 service with new pulse");
        uart_evt = 1'b1; insn_end = 1'b1;
        @(negedge clk);
        uart_evt = 1'b0; insn_end = 1'b0;
        boundary(1, 12, 1, "R10 new pulse kept");
        boundary(0, 0, 0, "R10 drained");

        idle(3);
        if (exp_v_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R8 leftover expectations actual=%0d expected=0", exp_v_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule